// File: doc/BRIEF.md
# SPI Register Slave with Word Parity

This block is an SPI slave that gives a master read and write access to a small register file. The master sends 16-bit command words. The reply to each command is shifted out during the following word, so the MISO pipeline is exactly one word deep. A write returns the value the register held before it was overwritten. To collect the reply to its last command, the master sends one more all-zero word. That word is a read of the status register.

Register 1 holds a parity enable bit. When it is set, every word in both directions grows to 17 bits: the 16 word bits are followed by a parity bit under an odd or even rule selected in the same register. A received parity error sets a sticky flag and cancels a write. A read with a bad parity bit still returns the addressed register.

SCK, MOSI and chip select are oversampled by the system clock through a synchronizer. A three-state machine drives each frame:
- FS_IDLE, while chip select is high. FS_IDLE → FS_SHIFT when chip select falls, and the first-word status is loaded.
- FS_SHIFT, while bits are moving. FS_SHIFT → FS_EXEC on the rising SCK edge of the last bit. FS_SHIFT → FS_IDLE if chip select rises.
- FS_EXEC, one clock in which the command executes. FS_EXEC → FS_SHIFT for the next word, or FS_EXEC → FS_IDLE if chip select has risen.

A committed write also appears on a one-cycle register write port.

Top module: `spi_par_slave`

## Requirements
- R1: While chip select is high, MISO is low. The first word of a session returns a reply word whose bit 10 (first-word marker) is 1, whose bit 8 is the current parity error flag, and whose bits 7:0 are 0x00. Bits 15:11 of every reply word are 0.
- R2: The command word carries the address in bits 15:10 and the read/write bit in bit 9 (1 = write). Bit 8 is ignored. Bits 7:0 are the write data. Words are shifted MSB first in SPI mode 0: MOSI is sampled on rising SCK, and MISO changes on falling SCK.
- R3: The reply to a read arrives in the next word. Its bits 7:0 hold the addressed register and its bit 9 (write marker) is 0.
- R4: A write stores its data. The reply in the next word has bit 9 set to 1 and bits 7:0 equal to the value before the write. The write port pulses for one clock with the address and data.
- R5: Register 0 is status. Bit 0 is the parity error flag and the other bits read 0. Writes to register 0 do nothing and raise no port pulse. A read of register 0 returns the flag and then clears it. In the reply, bit 8 shows the flag after this clear.
- R6: Register 1 is identification/configuration. Bit 0 enables parity and bit 1 selects the odd rule (1) or the even rule (0). Only bits 1:0 can be written, and bits 7:2 keep their reset value. A new setting applies from the word after the write.
- R7: With parity enabled, each frame has 17 SCK cycles. The 17th bit is the XOR of the 16 word bits under the even rule and its inverse under the odd rule. The slave appends a parity bit of its own to each MISO word under the same rule.
- R8: A write received with a wrong parity bit sets the flag and stores nothing, with no port pulse. Its reply carries the old register value with bit 8 set.
- R9: A read received with a wrong parity bit sets the flag and still replies with the contents of the received address. Any corrupted bit of the word has the same effect.
- R10: If chip select rises before a full frame, the partial word is dropped: no write and no flag change. The next session starts again with the first-word reply.
- R11: After reset, general registers are 0x00, the flag is clear, register 1 is 0xA0 (parity off), MISO is low and the write port is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the master, idle low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| reg_wr_en | output | 1 | One-cycle pulse when a write commits |
| reg_wr_addr | output | ADDR_W | Address of the committed write |
| reg_wr_data | output | DATA_W | Data of the committed write |

## Verification
A behavioural model drives command streams that mix reads, writes, writes to the read-only status register and words with the reserved bit set. Each reply is compared to the request from one word earlier, which tells a correct one-word delay apart from an off-by-one shift and old-value write replies apart from new-value ones. The same traffic runs under parity off, even parity and odd parity, with parity bits corrupted on a write and on a read, so that cancellation, the sticky flag and its clear on a status read are each observed. A session cut off after 9 bits followed by a new session separates a dropped partial word from one that commits.

// File: rtl/spi_par_pkg.sv
package spi_par_pkg;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_SHIFT = 2'd1,
        FS_EXEC  = 2'd2
    } fr_state_e;

    // Bit positions inside the reply flag field (above the data byte)
    localparam int FLAG_PERR  = 0;
    localparam int FLAG_WR    = 1;
    localparam int FLAG_FIRST = 2;

    // Bit positions inside the configuration register
    localparam int CFG_EN_BIT  = 0;
    localparam int CFG_ODD_BIT = 1;

endpackage

// File: rtl/spi_par_sync.sv
module spi_par_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);

    for (genvar s = 0; s < STAGES; s++) begin : g_st
        logic [W-1:0] q;
        if (s == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= d_in;
            end
        end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= g_st[s-1].q;
            end
        end
    end

    assign q_out = g_st[STAGES-1].q;

endmodule

// File: rtl/spi_par_frame.sv
module spi_par_frame
    import spi_par_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic              cfg_en,
    input  logic              cfg_odd,
    input  logic [WORD_W-1:0] first_word,
    input  logic [WORD_W-1:0] reply_word,
    output logic              miso,
    output logic              word_valid,
    output logic              par_en_q,
    output logic              par_odd_q,
    output logic              rx_par,
    output logic [WORD_W-1:0] rx_word
);

    localparam int FR_W  = WORD_W + 1;
    localparam int CNT_W = $clog2(FR_W + 1);

    fr_state_e        st_q, st_d;
    logic             sck_d;
    logic             sck_rise, sck_fall, last_bit;
    logic             load_pend;
    logic [CNT_W-1:0] bit_cnt, fr_len;
    logic [FR_W-1:0]  rx_sh, tx_sh;

    function automatic logic [FR_W-1:0] with_par(input logic [WORD_W-1:0] w,
                                                 input logic odd);
        return {w, odd ? ~(^w) : (^w)};
    endfunction

    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;
    assign fr_len   = par_en_q ? CNT_W'(FR_W) : CNT_W'(WORD_W);
    assign last_bit = sck_rise && (bit_cnt == fr_len - 1'b1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FS_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FS_IDLE:  if (!cs_n_s) st_d = FS_SHIFT;
            FS_SHIFT: begin
                if (cs_n_s)        st_d = FS_IDLE;
                else if (last_bit) st_d = FS_EXEC;
            end
            FS_EXEC:  st_d = cs_n_s ? FS_IDLE : FS_SHIFT;
            default:  st_d = FS_IDLE;
        endcase
    end

    // Outputs and shift datapath
    assign word_valid = (st_q == FS_EXEC);
    assign miso       = (st_q != FS_IDLE) & tx_sh[FR_W-1];
    assign rx_word    = par_en_q ? rx_sh[FR_W-1:1] : rx_sh[WORD_W-1:0];
    assign rx_par     = rx_sh[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d     <= 1'b0;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            load_pend <= 1'b0;
            par_en_q  <= 1'b0;
            par_odd_q <= 1'b0;
        end else begin
            sck_d <= sck_s;
            unique case (st_q)
                FS_IDLE: begin
                    bit_cnt   <= '0;
                    load_pend <= 1'b0;
                    if (!cs_n_s) begin
                        tx_sh     <= with_par(first_word, cfg_odd);
                        par_en_q  <= cfg_en;
                        par_odd_q <= cfg_odd;
                    end else begin
                        tx_sh <= '0;
                    end
                end
                FS_SHIFT: begin
                    if (sck_rise) begin
                        rx_sh   <= {rx_sh[FR_W-2:0], mosi_s};
                        bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
                    end
                    if (sck_fall) begin
                        if (load_pend) begin
                            tx_sh     <= with_par(reply_word, cfg_odd);
                            par_en_q  <= cfg_en;
                            par_odd_q <= cfg_odd;
                            load_pend <= 1'b0;
                        end else if (bit_cnt != '0) begin
                            tx_sh <= {tx_sh[FR_W-2:0], 1'b0};
                        end
                    end
                end
                FS_EXEC: load_pend <= 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/spi_par_regs.sv
module spi_par_regs
    import spi_par_pkg::*;
#(
    parameter int                ADDR_W = 6,
    parameter int                DATA_W = 8,
    parameter logic [DATA_W-1:0] ID_RST = 8'hA0,
    localparam int               WORD_W = ADDR_W + DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              rx_par,
    input  logic              chk_en,
    input  logic              chk_odd,
    output logic [WORD_W-1:0] reply_q,
    output logic              perr_q,
    output logic              cfg_en,
    output logic              cfg_odd,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam int              DEPTH = 2 ** ADDR_W;
    localparam int              FL_W  = WORD_W - DATA_W;
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data, rd_val;
    logic [FL_W-1:0]   flags;
    logic              cmd_wr, exp_par, par_bad, perr_nxt, commit;

    always_comb begin
        cmd_addr = rx_word[WORD_W-1 -: ADDR_W];
        cmd_wr   = rx_word[DATA_W+1];
        cmd_data = rx_word[DATA_W-1:0];
        exp_par  = chk_odd ? ~(^rx_word) : (^rx_word);
        par_bad  = chk_en && (rx_par != exp_par);
        rd_val   = (cmd_addr == STAT_A) ? DATA_W'(perr_q) : mem[cmd_addr];
        if (par_bad)                              perr_nxt = 1'b1;
        else if (!cmd_wr && cmd_addr == STAT_A)   perr_nxt = 1'b0;
        else                                      perr_nxt = perr_q;
        commit   = cmd_wr && !par_bad && (cmd_addr != STAT_A);
        flags            = '0;
        flags[FLAG_PERR] = perr_nxt;
        flags[FLAG_WR]   = cmd_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            mem[CFG_A] <= ID_RST;
            perr_q     <= 1'b0;
            reply_q    <= '0;
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
        end else begin
            wr_en <= 1'b0;
            if (word_valid) begin
                perr_q  <= perr_nxt;
                reply_q <= {flags, rd_val};
                wr_en   <= commit;
                wr_addr <= cmd_addr;
                wr_data <= cmd_data;
                if (commit) begin
                    mem[cmd_addr] <= (cmd_addr == CFG_A)
                                   ? {ID_RST[DATA_W-1:2], cmd_data[1:0]}
                                   : cmd_data;
                end
            end
        end
    end

    assign cfg_en  = mem[CFG_A][CFG_EN_BIT];
    assign cfg_odd = mem[CFG_A][CFG_ODD_BIT];

endmodule

// File: rtl/spi_par_slave.sv
module spi_par_slave
    import spi_par_pkg::*;
#(
    parameter int                ADDR_W      = 6,
    parameter int                DATA_W      = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] ID_RST      = 8'hA0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              reg_wr_en,
    output logic [ADDR_W-1:0] reg_wr_addr,
    output logic [DATA_W-1:0] reg_wr_data
);

    localparam int WORD_W = ADDR_W + DATA_W + 2;
    localparam int FL_W   = WORD_W - DATA_W;

    logic              cs_n_s, sck_s, mosi_s;
    logic              w_valid, perr_flag, cfg_en, cfg_odd;
    logic              par_en_q, par_odd_q, rx_par;
    logic [WORD_W-1:0] rx_word, reply_word, first_word;
    logic [FL_W-1:0]   first_fl;

    spi_par_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in ({spi_cs_n, spi_sck, spi_mosi}),
        .q_out({cs_n_s, sck_s, mosi_s})
    );

    always_comb begin
        first_fl             = '0;
        first_fl[FLAG_FIRST] = 1'b1;
        first_fl[FLAG_PERR]  = perr_flag;
        first_word           = {first_fl, {DATA_W{1'b0}}};
    end

    spi_par_frame #(
        .WORD_W(WORD_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (cs_n_s),
        .sck_s     (sck_s),
        .mosi_s    (mosi_s),
        .cfg_en    (cfg_en),
        .cfg_odd   (cfg_odd),
        .first_word(first_word),
        .reply_word(reply_word),
        .miso      (spi_miso),
        .word_valid(w_valid),
        .par_en_q  (par_en_q),
        .par_odd_q (par_odd_q),
        .rx_par    (rx_par),
        .rx_word   (rx_word)
    );

    spi_par_regs #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .ID_RST(ID_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_valid(w_valid),
        .rx_word   (rx_word),
        .rx_par    (rx_par),
        .chk_en    (par_en_q),
        .chk_odd   (par_odd_q),
        .reply_q   (reply_word),
        .perr_q    (perr_flag),
        .cfg_en    (cfg_en),
        .cfg_odd   (cfg_odd),
        .wr_en     (reg_wr_en),
        .wr_addr   (reg_wr_addr),
        .wr_data   (reg_wr_data)
    );

endmodule

// File: rtl/spi_par_chk.sv
module spi_par_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              miso,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              word_valid,
    input logic              perr
);

    logic [2:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    // R1
    idle_miso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd5 && cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3))
        |-> !miso);

    // R4
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R5
    wr_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr != '0));

    // R10
    wr_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd1 && wr_en) |-> $past(word_valid));

    // R10
    perr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd1 && !$past(word_valid)) |-> $stable(perr));

endmodule

bind spi_par_slave spi_par_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (spi_cs_n),
    .miso      (spi_miso),
    .wr_en     (reg_wr_en),
    .wr_addr   (reg_wr_addr),
    .word_valid(w_valid),
    .perr      (perr_flag)
);

// File: tb/sim_spi_par_slave.sv
module sim_spi_par_slave;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       miso;
    logic       wr_en;
    logic [5:0] wr_addr;
    logic [7:0] wr_data;

    int checks = 0;
    int errors = 0;
    int idle_cnt = 0;
    bit done = 0;

    // behavioural model state
    logic [7:0]  m_mem [0:63];
    logic        m_perr;
    logic [16:0] exp_cur;
    int          cur_len;
    int          exp_wr[$];
    int          got_wr[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_par_slave u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_cs_n   (cs_n),
        .spi_sck    (sck),
        .spi_mosi   (mosi),
        .spi_miso   (miso),
        .reg_wr_en  (wr_en),
        .reg_wr_addr(wr_addr),
        .reg_wr_data(wr_data)
    );

    function automatic logic par_of(input logic [15:0] w, input logic odd);
        return odd ? ~(^w) : (^w);
    endfunction

    function automatic logic [15:0] rd(input logic [5:0] a);
        return {a, 1'b0, 1'b0, 8'h00};
    endfunction

    function automatic logic [15:0] wr(input logic [5:0] a, input logic [7:0] d);
        return {a, 1'b1, 1'b0, d};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // write port monitor and per-clock idle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en) got_wr.push_back(int'({wr_addr, wr_data}));
            if (cs_n) idle_cnt++;
            else      idle_cnt = 0;
            if (idle_cnt > 6) check("R1 idle miso", 32'(miso), 32'd0);
        end
    end

    task automatic start_session();
        logic [15:0] r;
        @(negedge clk);
        cs_n = 1'b0;
        cur_len = m_mem[1][0] ? 17 : 16;
        r = {5'b0, 1'b1, 1'b0, m_perr, 8'h00};
        exp_cur = {r, par_of(r, m_mem[1][1])};
        repeat (HALF) @(negedge clk);
    endtask

    task automatic end_session();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
    endtask

    task automatic xfer(input logic [15:0] w, input bit flip, input int nbits, input string tag);
        logic [16:0] fr, cap;
        logic [5:0]  a;
        logic [7:0]  d, rv;
        logic [15:0] r;
        logic        np, bad, wbit;
        int          len, nb;
        len = cur_len;
        fr  = {w, par_of(w, m_mem[1][1]) ^ flip};
        nb  = (nbits == 0) ? len : nbits;
        cap = '0;
        for (int i = 0; i < nb; i++) begin
            mosi = fr[16-i];
            repeat (HALF) @(negedge clk);
            cap[16-i] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        if (nb == len) begin
            check({tag, " reply word"}, 32'(cap[16:1]), 32'(exp_cur[16:1]));
            if (len == 17) check("R7 slave parity bit", 32'(cap[0]), 32'(exp_cur[0]));
            // model execution of the received word
            a    = w[15:10];
            wbit = w[9];
            d    = w[7:0];
            bad  = (len == 17) && flip;
            rv   = (a == 6'd0) ? {7'b0, m_perr} : m_mem[a];
            np   = bad ? 1'b1 : ((!wbit && a == 6'd0) ? 1'b0 : m_perr);
            if (wbit && !bad && a != 6'd0) begin
                m_mem[a] = (a == 6'd1) ? {6'b101000, d[1:0]} : d;
                exp_wr.push_back(int'({a, d}));
            end
            m_perr  = np;
            r       = {5'b0, 1'b0, wbit, np, rv};
            exp_cur = {r, par_of(r, m_mem[1][1])};
            cur_len = m_mem[1][0] ? 17 : 16;
            repeat (4) @(negedge clk);
            check("R4 write port count", 32'(got_wr.size()), 32'(exp_wr.size()));
            while (got_wr.size() > 0 && exp_wr.size() > 0) begin
                check("R4 write port addr/data", 32'(got_wr.pop_front()), 32'(exp_wr.pop_front()));
            end
            got_wr.delete();
            exp_wr.delete();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) m_mem[i] = 8'h00;
        m_mem[1] = 8'hA0;
        m_perr   = 1'b0;
        repeat (5) @(negedge clk);
        // R11: reset state at the ports
        check("R11 miso in reset", 32'(miso), 32'd0);
        check("R11 write port in reset", 32'(wr_en), 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // Session 1: parity off, then even, then odd
        start_session();
        xfer(rd(6'd1), 0, 0, "R1 first word");
        xfer(rd(6'd2), 0, 0, "R11 ident reset value");
        xfer(wr(6'd3, 8'h5A), 0, 0, "R3 read reg2");
        xfer(rd(6'd3), 0, 0, "R4 old value on write");
        xfer(wr(6'd3, 8'hC3) | 16'h0100, 0, 0, "R3 read after write");
        xfer(rd(6'd3), 0, 0, "R2 reserved bit ignored");
        xfer(wr(6'd0, 8'hFF), 0, 0, "R2 data shift");
        xfer(rd(6'd0), 0, 0, "R5 status write reply");
        xfer(wr(6'd1, 8'h01), 0, 0, "R5 status not written");
        xfer(rd(6'd3), 0, 0, "R6 config write reply");
        xfer(wr(6'd4, 8'h77), 1, 0, "R7 first parity frame");
        xfer(rd(6'd4), 0, 0, "R8 bad write reply");
        xfer(rd(6'd0), 0, 0, "R8 write cancelled");
        xfer(rd(6'd5) | 16'h003C, 1, 0, "R5 status read clears");
        xfer(wr(6'd1, 8'h03), 0, 0, "R9 bad read reply");
        xfer(rd(6'd3), 0, 0, "R6 odd select reply");
        xfer(rd(6'd0), 0, 0, "R7 odd parity reply");
        xfer(16'h0000, 0, 0, "R5 status after read");
        xfer(wr(6'd6, 8'h11), 0, 0, "R5 zero word reply");
        end_session();

        // Session 2: partial word dropped
        start_session();
        xfer(wr(6'd7, 8'hAA), 0, 9, "R10 partial");
        end_session();

        // Session 3
        start_session();
        xfer(rd(6'd7), 0, 0, "R10 first word after partial");
        xfer(wr(6'd1, 8'h00), 0, 0, "R10 partial write dropped");
        xfer(rd(6'd6), 0, 0, "R6 parity off reply");
        xfer(16'h0000, 0, 0, "R4 earlier write kept");
        end_session();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule